// File: doc/BRIEF.md
# Register-Indexed Permutation Address Unit

This unit turns a plain element counter into a stream of indirect element indices. Each run starts from a 32-bit shape word. The counter is first walked through a small two-dimensional loop nest, which can swap the loop order (transpose), run either axis backwards (mirror), or drop the inner axis (skip). The resulting position selects one packed index value held in a register file. The unit reads that value through a synchronous read port, adds a small constant, and presents the sum as the element index.

Because the loop remap is applied before the lookup, a table of indices that is stored row by row can be consumed column by column or mirrored, and the table never has to be copied. The output uses a valid/ready pair. When the consumer stalls, the element counter holds, and the unit reads the same register again so that the presented index stays fixed. Index values that exceed the vector length are not checked, and the result of using them is undefined by contract.

Top module: `idx_perm_agu`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `busy_o`, `rd_en_o` and `out_valid_o` are 0.
- R2: A start is accepted only when all of these hold: the unit is idle (`busy_o` and `out_valid_o` are 0), shape bits [31:30] are 00, shape bits [20:19] are 11, and `len_i` is non-zero. Any other start causes no read and leaves `busy_o` at 0. When the unit is idle, `rd_en_o` is 0.
- R3: Let X = shape[5:0]+1 and Y = shape[11:6]+1. Shape bit 18 sets the loop order. With bit 18 = 0, x is the inner axis: for element i, x = i mod X and y = (i div X) mod Y. With bit 18 = 1, y is the inner axis: y = i mod Y and x = (i div Y) mod X. The position is x' + X*y'.
- R4: Shape bit 21 mirrors x (x' = X-1-x), and shape bit 22 mirrors y (y' = Y-1-y). When a bit is clear, the coordinate is used as counted.
- R5: Shape bit 23 drops the inner axis. The position is then the mirrored outer coordinate alone: y' when bit 18 = 0, x' when bit 18 = 1.
- R6: Shape bits [29:28] give the lane shift s. For a position p, the register read address is ((shape[17:12] << 1) + (p >> s)) mod 2^REG_AW.
- R7: The value of s selects the lane width: 0 selects 64 bits, 1 selects 32 bits, 2 selects 16 bits and 3 selects 8 bits. The lane used is p mod 2^s, and lane 0 is the least significant bits of the register.
- R8: The output index is the zero-extended lane value plus shape[27:24], taken modulo 2^IDX_W.
- R9: `out_valid_o` is high in the cycle after each read is issued. While the consumer stays ready, the unit delivers one index per cycle.
- R10: While `out_valid_o` is 1 and `out_ready_i` is 0, the counter holds and `idx_o` does not change. Exactly `len_i` indices are delivered. The position sequence wraps around after X*Y elements.
- R11: A start pulse that arrives while a run is in progress has no effect on that run's indices or on its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a run |
| shape_i | input | 32 | Shape word, sampled on an accepted start |
| len_i | input | CNT_W | Number of indices to produce |
| busy_o | output | 1 | Run in progress (reads still to be issued) |
| rd_en_o | output | 1 | Register read strobe |
| rd_addr_o | output | REG_AW | Register read address |
| rd_data_i | input | 64 | Read data, returned one cycle after the strobe |
| out_valid_o | output | 1 | Index valid |
| out_ready_i | input | 1 | Consumer accepts the index |
| idx_o | output | IDX_W | Element index |

## Verification
The bound checker checks the following on every cycle. It checks the link between the read strobe and the valid flag in both directions, in the form of a read followed by valid and a valid preceded by a read. It also checks that an idle unit issues no reads, and that a stalled index holds steady. Only the bench scenarios can show the arithmetic content. That content covers the order of loop positions under transpose, mirror and skip; lane extraction for each width; the address base and shift; the offset sum; wrap-around past the grid; and the fact that starts which are rejected or arrive mid-run leave no trace.

// File: rtl/idx_perm_pkg.sv
package idx_perm_pkg;

   localparam int DIM_W  = 6;
   localparam int POS_W  = 12;
   localparam int WORD_W = 64;

   typedef struct packed {
      logic [1:0]       lane_shift;
      logic [3:0]       bias;
      logic             drop_inner;
      logic             flip_y;
      logic             flip_x;
      logic             y_inner;
      logic [DIM_W-1:0] base_half;
      logic [DIM_W-1:0] y_last;
      logic [DIM_W-1:0] x_last;
   } shape_cfg_t;

   function automatic logic shape_is_indexed(input logic [31:0] w);
      return (w[31:30] == 2'b00) && (w[20:19] == 2'b11);
   endfunction

   function automatic shape_cfg_t shape_decode(input logic [31:0] w);
      shape_cfg_t c;
      c.lane_shift = w[29:28];
      c.bias       = w[27:24];
      c.drop_inner = w[23];
      c.flip_y     = w[22];
      c.flip_x     = w[21];
      c.y_inner    = w[18];
      c.base_half  = w[17:12];
      c.y_last     = w[11:6];
      c.x_last     = w[5:0];
      return c;
   endfunction

endpackage

// File: rtl/idx_loop_gen.sv
module idx_loop_gen
   import idx_perm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  shape_cfg_t       cfg_i,
   output logic [POS_W-1:0] pos_o
);

   logic [DIM_W-1:0] xc_q, yc_q;
   logic [DIM_W-1:0] xm, ym;
   logic             x_wrap, y_wrap;
   logic [POS_W-1:0] x_len;

   assign x_wrap = (xc_q == cfg_i.x_last);
   assign y_wrap = (yc_q == cfg_i.y_last);

   always_ff @(posedge clk) begin
      if (!rst_n || load_i) begin
         xc_q <= '0;
         yc_q <= '0;
      end else if (step_i) begin
         if (cfg_i.y_inner) begin
            yc_q <= y_wrap ? '0 : yc_q + 1'b1;
            if (y_wrap) xc_q <= x_wrap ? '0 : xc_q + 1'b1;
         end else begin
            xc_q <= x_wrap ? '0 : xc_q + 1'b1;
            if (x_wrap) yc_q <= y_wrap ? '0 : yc_q + 1'b1;
         end
      end
   end

   assign xm    = cfg_i.flip_x ? (cfg_i.x_last - xc_q) : xc_q;
   assign ym    = cfg_i.flip_y ? (cfg_i.y_last - yc_q) : yc_q;
   assign x_len = POS_W'(cfg_i.x_last) + POS_W'(1);

   always_comb begin
      if (cfg_i.drop_inner)
         pos_o = cfg_i.y_inner ? POS_W'(xm) : POS_W'(ym);
      else
         pos_o = POS_W'(xm) + x_len * POS_W'(ym);
   end

endmodule

// File: rtl/idx_lane_sel.sv
module idx_lane_sel
   import idx_perm_pkg::*;
#(
   parameter int IDX_W = 16
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [2:0]        lane_i,
   input  logic [1:0]        shift_i,
   input  logic [3:0]        bias_i,
   output logic [IDX_W-1:0]  idx_o
);

   localparam int N32 = WORD_W / 32;
   localparam int N16 = WORD_W / 16;
   localparam int N8  = WORD_W / 8;

   logic [31:0]      w32 [N32];
   logic [15:0]      w16 [N16];
   logic [7:0]       w8  [N8];
   logic [IDX_W-1:0] raw;

   for (genvar g = 0; g < N32; g++) begin : g_l32
      assign w32[g] = word_i[32*g +: 32];
   end
   for (genvar g = 0; g < N16; g++) begin : g_l16
      assign w16[g] = word_i[16*g +: 16];
   end
   for (genvar g = 0; g < N8; g++) begin : g_l8
      assign w8[g] = word_i[8*g +: 8];
   end

   always_comb begin
      case (shift_i)
         2'd0:    raw = IDX_W'(word_i);
         2'd1:    raw = IDX_W'(w32[lane_i[0]]);
         2'd2:    raw = IDX_W'(w16[lane_i[1:0]]);
         default: raw = IDX_W'(w8[lane_i]);
      endcase
   end

   assign idx_o = raw + IDX_W'(bias_i);

endmodule

// File: rtl/idx_perm_agu.sv
module idx_perm_agu
   import idx_perm_pkg::*;
#(
   parameter int CNT_W  = 7,
   parameter int REG_AW = 7,
   parameter int IDX_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [31:0]       shape_i,
   input  logic [CNT_W-1:0]  len_i,
   output logic              busy_o,
   output logic              rd_en_o,
   output logic [REG_AW-1:0] rd_addr_o,
   input  logic [63:0]       rd_data_i,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [IDX_W-1:0]  idx_o
);

   if (REG_AW < DIM_W + 1) begin : g_bad_aw
      $error("REG_AW must hold the doubled base field");
   end
   if (IDX_W < 8 || IDX_W > WORD_W) begin : g_bad_idx
      $error("IDX_W out of range");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end

   shape_cfg_t        cfg_q;
   logic              busy_q, valid_q;
   logic [CNT_W-1:0]  left_q;
   logic [REG_AW-1:0] held_addr_q;
   logic [2:0]        held_lane_q;

   logic              accept, stall, adv;
   logic [POS_W-1:0]  pos;
   logic [REG_AW-1:0] cur_addr;
   logic [2:0]        cur_lane;

   assign accept = start_i && !busy_q && !valid_q && shape_is_indexed(shape_i)
                   && (len_i != '0);
   assign stall  = valid_q && !out_ready_i;
   assign adv    = busy_q && !stall;

   idx_loop_gen u_loop (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .step_i (adv),
      .cfg_i  (cfg_q),
      .pos_o  (pos)
   );

   assign cur_addr = REG_AW'({cfg_q.base_half, 1'b0}) + REG_AW'(pos >> cfg_q.lane_shift);

   always_comb begin
      case (cfg_q.lane_shift)
         2'd0:    cur_lane = 3'd0;
         2'd1:    cur_lane = {2'b00, pos[0]};
         2'd2:    cur_lane = {1'b0, pos[1:0]};
         default: cur_lane = pos[2:0];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q       <= '0;
         busy_q      <= 1'b0;
         valid_q     <= 1'b0;
         left_q      <= '0;
         held_addr_q <= '0;
         held_lane_q <= '0;
      end else begin
         if (accept) begin
            cfg_q  <= shape_decode(shape_i);
            busy_q <= 1'b1;
            left_q <= len_i;
         end
         if (adv) begin
            left_q      <= left_q - 1'b1;
            held_addr_q <= cur_addr;
            held_lane_q <= cur_lane;
            if (left_q == CNT_W'(1)) busy_q <= 1'b0;
         end
         if (adv)         valid_q <= 1'b1;
         else if (!stall) valid_q <= 1'b0;
      end
   end

   assign busy_o      = busy_q;
   assign out_valid_o = valid_q;
   assign rd_en_o     = adv || stall;
   assign rd_addr_o   = stall ? held_addr_q : cur_addr;

   idx_lane_sel #(.IDX_W(IDX_W)) u_lane (
      .word_i  (rd_data_i),
      .lane_i  (held_lane_q),
      .shift_i (cfg_q.lane_shift),
      .bias_i  (cfg_q.bias),
      .idx_o   (idx_o)
   );

endmodule

// File: rtl/idx_perm_agu_chk.sv
module idx_perm_agu_chk #(
   parameter int IDX_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy_o,
   input logic             rd_en_o,
   input logic             out_valid_o,
   input logic             out_ready_i,
   input logic [IDX_W-1:0] idx_o
);

   // R2
   idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !out_valid_o) |-> !rd_en_o);

   // R9
   read_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |=> out_valid_o);

   // R9
   valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> $past(rd_en_o));

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(idx_o)));

endmodule

bind idx_perm_agu idx_perm_agu_chk #(.IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy_o      (busy_o),
   .rd_en_o     (rd_en_o),
   .out_valid_o (out_valid_o),
   .out_ready_i (out_ready_i),
   .idx_o       (idx_o)
);

// File: tb/idx_perm_agu_test.sv
module idx_perm_agu_test;

   localparam int CNT_W  = 7;
   localparam int REG_AW = 7;
   localparam int IDX_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [31:0]       shape_i = '0;
   logic [CNT_W-1:0]  len_i = '0;
   logic              busy_o, rd_en_o, out_valid_o;
   logic [REG_AW-1:0] rd_addr_o;
   logic [63:0]       rd_data;
   logic              out_ready_i = 1'b1;
   logic [IDX_W-1:0]  idx_o;

   logic [63:0] regs [128];

   int n_chk = 0;
   int n_bad = 0;
   int ticks = 0;

   always #5 clk = ~clk;

   idx_perm_agu #(.CNT_W(CNT_W), .REG_AW(REG_AW), .IDX_W(IDX_W)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .shape_i     (shape_i),
      .len_i       (len_i),
      .busy_o      (busy_o),
      .rd_en_o     (rd_en_o),
      .rd_addr_o   (rd_addr_o),
      .rd_data_i   (rd_data),
      .out_valid_o (out_valid_o),
      .out_ready_i (out_ready_i),
      .idx_o       (idx_o)
   );

   always_ff @(posedge clk) if (rd_en_o) rd_data <= regs[rd_addr_o];

   always @(posedge clk) begin
      ticks++;
      if (ticks > 50000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, act=%0d exp<=50000 cycles", ticks);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int sh, input int bias, input bit drop,
         input bit fy, input bit fx, input bit yin, input int base, input int ylast,
         input int xlast);
      return {2'b00, 2'(sh), 4'(bias), drop, fy, fx, 2'b11, yin, 6'(base), 6'(ylast), 6'(xlast)};
   endfunction

   function automatic int ref_pos(input logic [31:0] s, input int i);
      int nx = int'(s[5:0]) + 1;
      int ny = int'(s[11:6]) + 1;
      int x, y, xp, yp;
      if (!s[18]) begin x = i % nx; y = (i / nx) % ny; end
      else        begin y = i % ny; x = (i / ny) % nx; end
      xp = s[21] ? nx - 1 - x : x;
      yp = s[22] ? ny - 1 - y : y;
      if (s[23]) return s[18] ? xp : yp;
      return xp + nx * yp;
   endfunction

   function automatic int ref_addr(input logic [31:0] s, input int i);
      return (int'(s[17:12]) * 2 + (ref_pos(s, i) >> s[29:28])) % 128;
   endfunction

   function automatic longint ref_idx(input logic [31:0] s, input int i);
      int sh = int'(s[29:28]);
      int lane = ref_pos(s, i) % (1 << sh);
      int w = 64 >> sh;
      logic [63:0] v = regs[ref_addr(s, i)] >> (w * lane);
      if (w < 64) v = v & ((64'd1 << w) - 1);
      return longint'((v + 64'(s[27:24])) & 64'hFFFF);
   endfunction

   task automatic run_case(input logic [31:0] s, input int len, input bit stall,
                           input bit poke, input string req);
      int k = 0;
      int cyc = 0;
      bit held = 0;
      bit seen = 0;
      logic [IDX_W-1:0] held_idx = '0;
      @(posedge clk); #1;
      shape_i = s; len_i = CNT_W'(len); start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0; shape_i = '0;
      while (!(k == len && !busy_o && !out_valid_o) && cyc < len * 4 + 20) begin
         @(negedge clk);
         out_ready_i = stall ? (cyc % 3 != 1) : 1'b1;
         if (poke && cyc == 2) begin
            start_i = 1'b1; shape_i = mk(3, 9, 0, 1, 1, 0, 40, 0, 3); len_i = 3;
         end else if (poke && cyc == 3) begin
            start_i = 1'b0;
         end
         #1;
         if (cyc == 0) begin
            chk(rd_en_o == 1'b1, "R6 first read strobe", rd_en_o, 1);
            chk(int'(rd_addr_o) == ref_addr(s, 0), "R6 first read address",
                rd_addr_o, ref_addr(s, 0));
            chk(out_valid_o == 1'b0, "R9 no valid in read cycle", out_valid_o, 0);
         end
         if (held)
            chk(out_valid_o && idx_o == held_idx, "R10 stalled index held", idx_o, held_idx);
         held = 0;
         if (out_valid_o) begin
            if (out_ready_i) begin
               if (k < len)
                  chk(longint'(idx_o) == ref_idx(s, k), req, idx_o, ref_idx(s, k));
               else
                  chk(0, "R10 extra index", k, len);
               k++;
               seen = 1;
            end else begin
               held = 1;
               held_idx = idx_o;
            end
         end else if (!stall && seen && k < len) begin
            chk(0, "R9 gap in stream", 0, 1);
         end
         cyc++;
      end
      out_ready_i = 1'b1;
      chk(k == len, "R10 delivered count", k, len);
      chk(busy_o == 1'b0, "R10 busy cleared at end", busy_o, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(!busy_o && !rd_en_o && !out_valid_o, "R1 outputs during reset",
          {busy_o, rd_en_o, out_valid_o}, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !rd_en_o && !out_valid_o, "R1 outputs after reset",
          {busy_o, rd_en_o, out_valid_o}, 0);
   endtask

   task automatic t_reject(input logic [31:0] s, input int len, input string req);
      @(posedge clk); #1;
      shape_i = s; len_i = CNT_W'(len); start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk(!busy_o && !rd_en_o && !out_valid_o, req, {busy_o, rd_en_o, out_valid_o}, 0);
      end
   endtask

   initial begin
      for (int a = 0; a < 128; a++)
         for (int j = 0; j < 8; j++)
            regs[a][8*j +: 8] = 8'((a * 8 + j) * 37 + 11);
      t_reset();
      // R3: x inner, 3x2 grid, 64-bit lanes, length wraps past the grid
      run_case(mk(0, 0, 0, 0, 0, 0, 4, 1, 2), 8, 0, 0, "R3 x-inner order");
      // R3 R7: transpose order with 32-bit lanes
      run_case(mk(1, 0, 0, 0, 0, 1, 10, 3, 2), 12, 0, 0, "R7 transpose 32-bit lanes");
      // R4 R8: both axes mirrored, 16-bit lanes, bias 5
      run_case(mk(2, 5, 0, 1, 1, 0, 20, 2, 3), 12, 0, 0, "R4 R8 mirrored with bias");
      // R4: x mirrored only, transpose
      run_case(mk(0, 1, 0, 0, 1, 1, 2, 2, 1), 6, 0, 0, "R4 x mirror only");
      // R5: drop inner x axis, 8-bit lanes
      run_case(mk(3, 2, 1, 0, 1, 0, 30, 3, 2), 12, 0, 0, "R5 skip inner x");
      // R5: drop inner y axis
      run_case(mk(3, 0, 1, 1, 0, 1, 8, 2, 3), 9, 0, 0, "R5 skip inner y");
      // R10: backpressure with a stall pattern
      run_case(mk(2, 5, 0, 1, 1, 0, 20, 2, 3), 12, 1, 0, "R10 indices under stall");
      // R2: wrong mode bits, wrong order code, zero length
      t_reject(mk(0, 0, 0, 0, 0, 0, 4, 1, 2) | 32'h4000_0000, 4, "R2 mode bits rejected");
      t_reject(mk(0, 0, 0, 0, 0, 0, 4, 1, 2) & ~32'h0008_0000, 4, "R2 order code rejected");
      t_reject(mk(0, 0, 0, 0, 0, 0, 4, 1, 2), 0, "R2 zero length rejected");
      // R11: a start pulse in mid-run is ignored
      run_case(mk(1, 3, 0, 0, 0, 0, 12, 1, 3), 8, 0, 1, "R11 mid-run start ignored");
      repeat (3) @(posedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule